// File: doc/BRIEF.md
# Soft Interrupt Priority Masking Register

This block keeps a software interrupt status word and a processor interrupt level, and turns the pair into one interrupt request line per status bit. The status word has 2**PIL_W + 1 bits. The top bit is the system timer match flag. Bit 0 is the tick match flag. The bits between them are software levels whose index is their priority.

Software writes through a single-cycle port. A one-hot select picks one of four targets: the status word written directly, an OR alias that sets bits, an AND-NOT alias that clears bits, or the level register. A timer match pulse from hardware sets the top status bit. Status and level are both visible on output ports. The request lines are registered, so they follow any change of status or level one clock later.

Top module: `softint_pil_ctrl`

## Requirements
- R1: After reset, status_o is 0, pil_o is 0 and irq_o is 0.
- R2: A write with select one-hot bit 0 (status) loads wr_data_i into the status word, visible on status_o after the accepting edge.
- R3: A write with select bit 1 (set alias) stores status OR wr_data_i.
- R4: A write with select bit 2 (clear alias) stores status AND NOT wr_data_i.
- R5: A write with select bit 3 (level) stores wr_data_i[PIL_W-1:0] into the level register.
- R6: irq_o[0] and irq_o[top] are high exactly when their status bit is set and the level is below TIMER_THR (default 14).
- R7: For each bit n from 1 to 2**PIL_W-1, irq_o[n] is high exactly when status bit n is set and n is strictly greater than the level.
- R8: irq_o reflects the status and level held in the previous cycle, so a write changes irq_o one edge after the write is accepted.
- R9: A tmr_hit_i pulse sets the top status bit, and it wins over any software write in the same cycle that would clear that bit.
- R10: A write whose select is not exactly one-hot, or that has wr_en_i low, changes neither status nor level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| wr_sel_i | input | 4 | One-hot target: 0 status, 1 set alias, 2 clear alias, 3 level |
| wr_data_i | input | 2**PIL_W+1 | Write data |
| tmr_hit_i | input | 1 | Hardware timer match pulse, sets the top status bit |
| status_o | output | 2**PIL_W+1 | Current status word |
| pil_o | output | PIL_W | Current interrupt level |
| irq_o | output | 2**PIL_W+1 | Registered per-bit interrupt requests |

## Verification
The bench builds the block with its defaults, PIL_W = 4 and TIMER_THR = 14, which give 17 status bits and 16 levels. That size lets every level be crossed with a walking one over all 17 status bits and with dense patterns. Every level is therefore compared against every bit index. This covers both sides of the threshold for the two timer flags, and the equality edge n = level for the software bits.

// File: rtl/softint_pkg.sv
package softint_pkg;
  localparam int SEL_W = 4;
  typedef enum int {
    SEL_STAT = 0,
    SEL_SET  = 1,
    SEL_CLR  = 2,
    SEL_PIL  = 3
  } sel_idx_e;
endpackage

// File: rtl/softint_status_reg.sv
module softint_status_reg #(
  parameter int STAT_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_stat_i,
  input  logic              wr_set_i,
  input  logic              wr_clr_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              tmr_hit_i,
  output logic [STAT_W-1:0] stat_o
);
  logic [STAT_W-1:0] stat_q, sw_next, hw_mask;

  always_comb begin
    sw_next = stat_q;
    if (wr_stat_i)     sw_next = wr_data_i;
    else if (wr_set_i) sw_next = stat_q | wr_data_i;
    else if (wr_clr_i) sw_next = stat_q & ~wr_data_i;
    hw_mask = '0;
    hw_mask[STAT_W-1] = tmr_hit_i;
  end

  // hardware set applied last so it beats a concurrent clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= sw_next | hw_mask;
  end

  assign stat_o = stat_q;

  a_r3_set_or: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_set_i && !wr_stat_i) |=> ((stat_q & $past(stat_q | wr_data_i)) == $past(stat_q | wr_data_i)));
  a_r4_clr_andnot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_clr_i && !wr_set_i && !wr_stat_i && !tmr_hit_i) |=> (stat_q == $past(stat_q & ~wr_data_i)));
  a_r9_hit_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tmr_hit_i |=> stat_q[STAT_W-1]);
  a_r10_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_stat_i && !wr_set_i && !wr_clr_i && !tmr_hit_i) |=> $stable(stat_q));
endmodule

// File: rtl/softint_pil_reg.sv
module softint_pil_reg #(
  parameter int PIL_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [PIL_W-1:0] wr_data_i,
  output logic [PIL_W-1:0] pil_o
);
  logic [PIL_W-1:0] pil_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   pil_q <= '0;
    else if (wr_i) pil_q <= wr_data_i;
  end

  assign pil_o = pil_q;

  a_r5_pil_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (pil_q == $past(wr_data_i)));
  a_r10_pil_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pil_q));
endmodule

// File: rtl/softint_req_gen.sv
module softint_req_gen #(
  parameter int PIL_W     = 4,
  parameter int TIMER_THR = 14,
  localparam int STAT_W   = (1 << PIL_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_i,
  input  logic [PIL_W-1:0]  pil_i,
  output logic [STAT_W-1:0] irq_o
);
  logic [STAT_W-1:0] req_d, req_q;
  logic              below_thr;

  assign below_thr = (pil_i < PIL_W'(TIMER_THR));

  for (genvar n = 0; n < STAT_W; n++) begin : g_lvl
    if (n == 0 || n == STAT_W - 1) begin : g_tmr
      assign req_d[n] = stat_i[n] & below_thr;
      a_r6_tmr_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_i[n] && pil_i < PIL_W'(TIMER_THR)) |=> irq_o[n]);
      a_r6_tmr_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stat_i[n] || pil_i >= PIL_W'(TIMER_THR)) |=> !irq_o[n]);
    end else begin : g_sw
      assign req_d[n] = stat_i[n] & (PIL_W'(n) > pil_i);
      a_r7_sw_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stat_i[n] && pil_i < PIL_W'(n)) |=> irq_o[n]);
      a_r7_sw_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!stat_i[n] || pil_i >= PIL_W'(n)) |=> !irq_o[n]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= req_d;
  end

  assign irq_o = req_q;
endmodule

// File: rtl/softint_pil_ctrl.sv
module softint_pil_ctrl
  import softint_pkg::*;
#(
  parameter int PIL_W     = 4,
  parameter int TIMER_THR = 14,
  localparam int STAT_W   = (1 << PIL_W) + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [SEL_W-1:0]  wr_sel_i,
  input  logic [STAT_W-1:0] wr_data_i,
  input  logic              tmr_hit_i,
  output logic [STAT_W-1:0] status_o,
  output logic [PIL_W-1:0]  pil_o,
  output logic [STAT_W-1:0] irq_o
);
  logic             wr_ok;
  logic [SEL_W-1:0] sel;

  // malformed selects are dropped
  assign wr_ok = wr_en_i & $onehot(wr_sel_i);
  assign sel   = wr_ok ? wr_sel_i : '0;

  softint_status_reg #(.STAT_W(STAT_W)) u_stat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_stat_i (sel[SEL_STAT]),
    .wr_set_i  (sel[SEL_SET]),
    .wr_clr_i  (sel[SEL_CLR]),
    .wr_data_i (wr_data_i),
    .tmr_hit_i (tmr_hit_i),
    .stat_o    (status_o)
  );

  softint_pil_reg #(.PIL_W(PIL_W)) u_pil (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (sel[SEL_PIL]),
    .wr_data_i (wr_data_i[PIL_W-1:0]),
    .pil_o     (pil_o)
  );

  softint_req_gen #(.PIL_W(PIL_W), .TIMER_THR(TIMER_THR)) u_req (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .stat_i (status_o),
    .pil_i  (pil_o),
    .irq_o  (irq_o)
  );

  a_r2_stat_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_sel_i == 4'b0001 && !tmr_hit_i) |=> (status_o == $past(wr_data_i)));
  a_r1_irq_needs_stat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((irq_o & ~$past(status_o)) == '0));
endmodule

// File: tb/softint_pil_ctrl_bench.sv
module softint_pil_ctrl_bench;
  localparam int PIL_W = 4;
  localparam int THR   = 14;
  localparam int SW    = (1 << PIL_W) + 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_sel = '0;
  logic [SW-1:0] wr_data = '0;
  logic          hit = 1'b0;
  logic [SW-1:0] status, irq;
  logic [PIL_W-1:0] pil;

  int checks = 0;
  int bad = 0;
  logic [SW-1:0]    m_stat = '0;
  logic [PIL_W-1:0] m_pil = '0;

  always #4 clk = ~clk;

  softint_pil_ctrl #(.PIL_W(PIL_W), .TIMER_THR(THR)) u_softint_pil_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .tmr_hit_i(hit),
    .status_o(status), .pil_o(pil), .irq_o(irq)
  );

  function automatic logic [SW-1:0] exp_irq(logic [SW-1:0] s, logic [PIL_W-1:0] p);
    logic [SW-1:0] r;
    for (int n = 0; n < SW; n++) begin
      if (n == 0 || n == SW - 1) r[n] = s[n] && (int'(p) < THR);
      else                       r[n] = s[n] && (n > int'(p));
    end
    return r;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // drive at negedge, accepted on next posedge, return at following negedge
  task automatic wr(logic [3:0] sel, logic [SW-1:0] d, logic h = 1'b0, logic en = 1'b1);
    @(negedge clk);
    wr_en = en; wr_sel = sel; wr_data = d; hit = h;
    @(negedge clk);
    wr_en = 1'b0; wr_sel = '0; wr_data = '0; hit = 1'b0;
  endtask

  task automatic chk_all(string req);
    chk({req, " status"}, 32'(status), 32'(m_stat));
    chk({req, " pil"}, 32'(pil), 32'(m_pil));
    @(negedge clk); // irq is one register further
    chk({req, " R8 irq"}, 32'(irq), 32'(exp_irq(m_stat, m_pil)));
  endtask

  initial begin
    #200000;
    bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    logic [SW-1:0] pats [4];
    pats[0] = '1;
    pats[1] = 17'h0AAAA;
    pats[2] = 17'h15555;
    pats[3] = 17'h10001;
    repeat (3) @(negedge clk);
    chk("R1 status", 32'(status), 0);
    chk("R1 pil", 32'(pil), 0);
    chk("R1 irq", 32'(irq), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R6 R7 sweep: every level against walking ones and dense patterns
    for (int p = 0; p < (1 << PIL_W); p++) begin
      wr(4'b1000, SW'(p) | 17'h1fff0); m_pil = PIL_W'(p);
      chk("R5", 32'(pil), 32'(p));
      for (int b = 0; b < SW; b++) begin
        wr(4'b0001, SW'(1) << b); m_stat = SW'(1) << b;
        chk_all((b == 0 || b == SW - 1) ? "R6 walk" : "R7 walk");
      end
      for (int k = 0; k < 4; k++) begin
        wr(4'b0001, pats[k]); m_stat = pats[k];
        chk_all("R2 R6 R7 pattern");
      end
    end

    wr(4'b1000, 0); m_pil = 0;
    wr(4'b0001, 17'h00F0F); m_stat = 17'h00F0F;
    chk_all("R2");
    wr(4'b0010, 17'h10230); m_stat = m_stat | 17'h10230;
    chk_all("R3");
    wr(4'b0100, 17'h00F03); m_stat = m_stat & ~17'h00F03;
    chk_all("R4");
    wr(4'b0100, 17'h1FFFF); m_stat = '0;
    chk_all("R4 clear all");

    // R9 hit alone, then racing a clear and a direct write of zero
    wr(4'b0000, 0, 1'b1, 1'b0); m_stat[SW-1] = 1'b1;
    chk_all("R9 hit");
    wr(4'b0100, 17'h10000, 1'b1); m_stat[SW-1] = 1'b1;
    chk_all("R9 hit vs clear");
    wr(4'b0001, 17'h00005, 1'b1); m_stat = 17'h10005;
    chk_all("R9 hit vs status write");

    // R10 malformed or disabled writes
    wr(4'b0011, 17'h0FFFF); chk_all("R10 two-hot");
    wr(4'b1100, 17'h0000F); chk_all("R10 two-hot pil");
    wr(4'b0001, 17'h0FFFF, 1'b0, 1'b0); chk_all("R10 en low");
    wr(4'b1000, 17'h00007, 1'b0, 1'b0); chk_all("R10 en low pil");

    // R8: irq lags the state change by exactly one edge
    wr(4'b1000, 0); m_pil = 0;
    wr(4'b0001, 17'h00002); m_stat = 17'h00002;
    chk("R8 before", 32'(irq & 17'h00002), 0);
    @(negedge clk);
    chk("R8 after", 32'(irq & 17'h00002), 32'h2);

    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule